// File: doc/BRIEF.md
# Vector Widening Add/Subtract Unit

This unit carries out a lane-wise widening add or subtract on 128-bit vector operands. One operand already holds wide lanes. The other operand supplies narrow lanes taken from one 64-bit half of a second 128-bit register. Each narrow lane is extended to double width, either by zero-fill or by sign-fill, and is then added to or subtracted from the matching wide lane. The result keeps only the wide-lane width, so any carry or borrow out of the lane is dropped.

A 32-bit instruction word controls the operation. The unit decodes the element size, the half select, the signedness and the add/subtract choice from this word. Any word that is not one of the four legal forms raises an illegal flag. Register selection, operand fetch and write-back belong to the surrounding pipeline. The unit receives both operand values on ports and returns the destination index decoded from the word. All outputs are registered, so a result appears one clock after its inputs.

Top module: `simd_widen_addsub`

## Requirements
- R1: A synchronous active-high reset clears `result_o`, `illegal_o` and `dest_o` to zero, and the first cycle after reset still shows those zeros.
- R2: Outputs are registered. The outputs after a rising edge reflect the inputs sampled at that edge.
- R3: An instruction is legal only when bit 31 = 0, bits 28:24 = 01110, bit 21 = 1, bits 15:14 = 00 and bits 12:10 = 100. For any other word `illegal_o` is 1 and `result_o` is all zeros.
- R4: A size field (bits 23:22) of 3 is reserved. It sets `illegal_o` and forces a zero result, even when the rest of the word matches.
- R5: Size 0, 1 and 2 give narrow lanes of 8, 16 and 32 bits, wide lanes of 16, 32 and 64 bits, and 8, 4 and 2 lanes. Every one of the 128 result bits is written.
- R6: Bit 30 selects the narrow source. When it is 0, the narrow lanes come from bits 63:0 of `narrow_i`. When it is 1, they come from bits 127:64.
- R7: Bit 29 set zero-extends the narrow lane. Bit 29 clear sign-extends it.
- R8: Bit 13 set computes wide minus extended narrow. Bit 13 clear computes their sum. A zero narrow lane leaves the wide lane unchanged in either case.
- R9: Each result lane is the exact sum or difference taken modulo 2 to the power of the wide-lane width. There is no saturation.
- R10: `dest_o` carries instruction bits 4:0. The source-index fields (bits 20:16 and 9:5) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word |
| wide_i | input | 128 | Operand with wide lanes |
| narrow_i | input | 128 | Register supplying the narrow lanes from one half |
| result_o | output | 128 | Registered lane-wise result |
| illegal_o | output | 1 | Registered flag for an unrecognised or reserved encoding |
| dest_o | output | 5 | Registered destination register index |

## Verification
The bench builds the unit with its default parameters: 128-bit vectors and an 8-bit base lane. With these values all three legal element sizes exist as separate lane groups, so a sweep over size, half select, signedness and operation covers every lane slice and every extension path. Operand patterns placed at signed and unsigned extremes (0x80, 0x7F, all ones, zero) exercise carry and borrow wrap at each lane boundary. Words with single broken pattern bits and the reserved size show the illegal path.

// File: rtl/simd_wadd_pkg.sv
package simd_wadd_pkg;

  localparam int INSN_W = 32;
  localparam int SIZE_W = 2;
  localparam int REG_W  = 5;

  // fixed instruction bit positions
  localparam int BIT_HALF   = 30;
  localparam int BIT_UNSIGN = 29;
  localparam int BIT_SUB    = 13;
  localparam int SIZE_LO    = 22;
  localparam int RD_LO      = 0;

  localparam logic [SIZE_W-1:0] SIZE_RESERVED = 2'b11;

  typedef struct packed {
    logic              legal;
    logic              upper_half;
    logic              zero_ext;
    logic              do_sub;
    logic [SIZE_W-1:0] size;
    logic [REG_W-1:0]  rd;
  } wadd_op_t;

endpackage

// File: rtl/wadd_decode.sv
module wadd_decode
  import simd_wadd_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output wadd_op_t          op
);

  logic fixed_ok;
  logic size_ok;

  always_comb begin
    fixed_ok = (insn[31] == 1'b0)
            && (insn[28:24] == 5'b01110)
            && (insn[21] == 1'b1)
            && (insn[15:14] == 2'b00)
            && (insn[12:10] == 3'b100);
    size_ok  = (insn[SIZE_LO +: SIZE_W] != SIZE_RESERVED);

    op.legal      = fixed_ok && size_ok;
    op.upper_half = insn[BIT_HALF];
    op.zero_ext   = insn[BIT_UNSIGN];
    op.do_sub     = insn[BIT_SUB];
    op.size       = insn[SIZE_LO +: SIZE_W];
    op.rd         = insn[RD_LO +: REG_W];
  end

endmodule

// File: rtl/wadd_lane.sv
module wadd_lane #(
  parameter int NARROW_W = 8,
  localparam int WIDE_W  = 2 * NARROW_W
) (
  input  logic [WIDE_W-1:0]   wide_lane,
  input  logic [NARROW_W-1:0] narrow_lane,
  input  logic                zero_ext,
  input  logic                do_sub,
  output logic [WIDE_W-1:0]   lane_out
);

  logic              fill_bit;
  logic [WIDE_W-1:0] narrow_ext;

  always_comb begin
    fill_bit   = ~zero_ext & narrow_lane[NARROW_W-1];
    narrow_ext = {{NARROW_W{fill_bit}}, narrow_lane};
    if (do_sub) lane_out = wide_lane - narrow_ext;
    else        lane_out = wide_lane + narrow_ext;
  end

endmodule

// File: rtl/wadd_size_path.sv
module wadd_size_path #(
  parameter int VEC_W    = 128,
  parameter int BASE_W   = 8,
  parameter int SIZE_IDX = 0,
  localparam int HALF_W  = VEC_W / 2,
  localparam int NARROW_W = BASE_W << SIZE_IDX,
  localparam int WIDE_W  = 2 * NARROW_W,
  localparam int LANES   = HALF_W / NARROW_W
) (
  input  logic [VEC_W-1:0]  wide_vec,
  input  logic [HALF_W-1:0] narrow_half,
  input  logic              zero_ext,
  input  logic              do_sub,
  output logic [VEC_W-1:0]  path_out
);

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    wadd_lane #(.NARROW_W(NARROW_W)) u_lane (
      .wide_lane  (wide_vec[ln*WIDE_W +: WIDE_W]),
      .narrow_lane(narrow_half[ln*NARROW_W +: NARROW_W]),
      .zero_ext   (zero_ext),
      .do_sub     (do_sub),
      .lane_out   (path_out[ln*WIDE_W +: WIDE_W])
    );
  end

endmodule

// File: rtl/simd_widen_addsub.sv
module simd_widen_addsub
  import simd_wadd_pkg::*;
#(
  parameter int VEC_W     = 128,
  parameter int BASE_W    = 8,
  parameter int NUM_SIZES = 3,
  localparam int HALF_W   = VEC_W / 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [INSN_W-1:0]    insn_i,
  input  logic [VEC_W-1:0]     wide_i,
  input  logic [VEC_W-1:0]     narrow_i,
  output logic [VEC_W-1:0]     result_o,
  output logic                 illegal_o,
  output logic [REG_W-1:0]     dest_o
);

  wadd_op_t          op;
  logic [HALF_W-1:0] narrow_half;
  logic [VEC_W-1:0]  path_res [NUM_SIZES];
  logic [VEC_W-1:0]  result_d;

  wadd_decode u_decode (
    .insn(insn_i),
    .op  (op)
  );

  assign narrow_half = op.upper_half ? narrow_i[VEC_W-1:HALF_W] : narrow_i[HALF_W-1:0];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    wadd_size_path #(
      .VEC_W   (VEC_W),
      .BASE_W  (BASE_W),
      .SIZE_IDX(s)
    ) u_path (
      .wide_vec   (wide_i),
      .narrow_half(narrow_half),
      .zero_ext   (op.zero_ext),
      .do_sub     (op.do_sub),
      .path_out   (path_res[s])
    );
  end

  always_comb begin
    result_d = '0;
    for (int s = 0; s < NUM_SIZES; s++) begin
      if (int'(op.size) == s) result_d = path_res[s];
    end
    if (!op.legal) result_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      illegal_o <= 1'b0;
      dest_o    <= '0;
    end else begin
      result_o  <= result_d;
      illegal_o <= ~op.legal;
      dest_o    <= op.rd;
    end
  end

endmodule

// File: rtl/wadd_checker.sv
module wadd_checker #(
  parameter int VEC_W = 128,
  localparam int HALF_W = VEC_W / 2
) (
  input logic             clk,
  input logic             rst,
  input logic [31:0]      insn_i,
  input logic [VEC_W-1:0] wide_i,
  input logic [VEC_W-1:0] narrow_i,
  input logic [VEC_W-1:0] result_o,
  input logic             illegal_o,
  input logic [4:0]       dest_o
);

  logic [HALF_W-1:0] sel_half;
  assign sel_half = insn_i[30] ? narrow_i[VEC_W-1:HALF_W] : narrow_i[HALF_W-1:0];

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (result_o == '0 && !illegal_o && dest_o == '0)); // R1

  AST_ILLEGAL_ZERO_RESULT: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (result_o == '0)); // R3

  AST_RESERVED_SIZE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(insn_i[23:22]) == 2'b11) |-> illegal_o); // R4

  AST_ZERO_NARROW_KEEPS_WIDE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !illegal_o && $past(sel_half) == '0) |-> (result_o == $past(wide_i))); // R8

  AST_DEST_TRACKS_FIELD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (dest_o == $past(insn_i[4:0]))); // R10

endmodule

bind simd_widen_addsub wadd_checker #(.VEC_W(VEC_W)) u_wadd_checker (
  .clk      (clk),
  .rst      (rst),
  .insn_i   (insn_i),
  .wide_i   (wide_i),
  .narrow_i (narrow_i),
  .result_o (result_o),
  .illegal_o(illegal_o),
  .dest_o   (dest_o)
);

// File: tb/simd_widen_addsub_bench.sv
module simd_widen_addsub_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [31:0]  insn_i = '0;
  logic [127:0] wide_i = '0;
  logic [127:0] narrow_i = '0;
  logic [127:0] result_o;
  logic         illegal_o;
  logic [4:0]   dest_o;

  int n_vec  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  simd_widen_addsub u_simd_widen_addsub (
    .clk(clk), .rst(rst), .insn_i(insn_i), .wide_i(wide_i),
    .narrow_i(narrow_i), .result_o(result_o), .illegal_o(illegal_o), .dest_o(dest_o)
  );

  // base encodings
  localparam logic [31:0] ENC_SADD = 32'h0E201000;
  localparam logic [31:0] ENC_SSUB = 32'h0E203000;
  localparam logic [31:0] ENC_UADD = 32'h2E201000;
  localparam logic [31:0] ENC_USUB = 32'h2E203000;

  function automatic logic [31:0] mk(input int unsigned sz, input bit q, input bit u,
                                     input bit sb, input int unsigned rd);
    logic [31:0] w;
    w = sb ? (u ? ENC_USUB : ENC_SSUB) : (u ? ENC_UADD : ENC_SADD);
    w[30] = q;
    w[23:22] = sz[1:0];
    w[4:0] = rd[4:0];
    return w;
  endfunction

  task automatic model(input logic [31:0] ins, input logic [127:0] w, input logic [127:0] n,
                       output logic [127:0] r, output logic ill, output logic [4:0] d);
    bit ok;
    int ew, lanes;
    logic [63:0] half, m1, m2, a, b, s;
    ok = (ins[31] == 1'b0) && (ins[28:24] == 5'b01110) && ins[21] &&
         (ins[15:14] == 2'b00) && (ins[12:10] == 3'b100) && (ins[23:22] != 2'b11);
    d = ins[4:0];
    ill = !ok;
    r = '0;
    if (ok) begin
      ew = 8 << ins[23:22];
      lanes = 64 / ew;
      half = ins[30] ? n[127:64] : n[63:0];
      m1 = (64'd1 << ew) - 64'd1;
      m2 = (ew == 32) ? {64{1'b1}} : ((64'd1 << (2 * ew)) - 64'd1);
      for (int e = 0; e < lanes; e++) begin
        a = (w >> (e * 2 * ew)) & m2;
        b = (half >> (e * ew)) & m1;
        if (!ins[29] && b[ew-1]) b = b | ~m1;
        s = ins[13] ? (a - b) : (a + b);
        s = s & m2;
        r = r | ({64'd0, s} << (e * 2 * ew));
      end
    end
  endtask

  task automatic compare(input logic [127:0] er, input logic ei, input logic [4:0] ed,
                         input string tag);
    n_vec++;
    if (result_o !== er || illegal_o !== ei || dest_o !== ed) begin
      n_fail++;
      $display("FAIL %s: got result=%h illegal=%b dest=%0d, expected result=%h illegal=%b dest=%0d",
               tag, result_o, illegal_o, dest_o, er, ei, ed);
    end
  endtask

  // drive at a falling edge, check at the next falling edge (one register stage)
  task automatic apply(input logic [31:0] ins, input logic [127:0] w, input logic [127:0] n,
                       input string tag);
    logic [127:0] er;
    logic ei;
    logic [4:0] ed;
    insn_i = ins; wide_i = w; narrow_i = n;
    model(ins, w, n, er, ei, ed);
    @(negedge clk);
    compare(er, ei, ed, tag);
  endtask

  task automatic apply_known(input logic [31:0] ins, input logic [127:0] w, input logic [127:0] n,
                             input logic [127:0] er, input string tag);
    insn_i = ins; wide_i = w; narrow_i = n;
    @(negedge clk);
    compare(er, 1'b0, ins[4:0], tag);
  endtask

  logic [63:0] pats [6] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8080_8080_8080_8080,
                            64'h7F7F_7F7F_7F7F_7F7F, 64'h8000_0000_8000_0000,
                            64'h7FFF_FFFF_0000_0001};

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    insn_i = mk(0, 0, 0, 0, 7); wide_i = '1; narrow_i = '1;
    repeat (3) @(negedge clk);
    compare('0, 1'b0, 5'd0, "R1 during reset");
    rst = 1'b0;
    // first cycle after reset, outputs must follow input from that edge
    apply(mk(1, 0, 1, 0, 3), {64'h0001_0002_0003_0004, 64'h0005_0006_0007_0008},
          {64'h0, 64'h0101_0101_0101_0101}, "R2");

    // directed hand-computed values
    // R9 unsigned add size0: FFFF + 01 wraps to 0000 in every 16-bit lane
    apply_known(mk(0, 0, 1, 0, 1), {128{1'b1}}, {64'h0, 64'h0101_0101_0101_0101},
                128'h0, "R9");
    // R7 signed add size0: 0000 + sext(80) = FF80
    apply_known(mk(0, 0, 0, 0, 2), 128'h0, {64'h0, 64'h8080_8080_8080_8080},
                {8{16'hFF80}}, "R7");
    // R7 unsigned add size0: 0000 + zext(80) = 0080
    apply_known(mk(0, 0, 1, 0, 2), 128'h0, {64'h0, 64'h8080_8080_8080_8080},
                {8{16'h0080}}, "R7");
    // R8 signed sub size2: 5 - sext(FFFFFFFF) = 6
    apply_known(mk(2, 0, 0, 1, 4), {64'd5, 64'd5}, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF},
                {64'd6, 64'd6}, "R8");
    // R6 upper half: narrow high half is 1s, low half 0s, unsigned add size1
    apply_known(mk(1, 1, 1, 0, 5), 128'h0, {64'h0001_0001_0001_0001, 64'h0},
                {4{32'h0000_0001}}, "R6");
    apply_known(mk(1, 0, 1, 0, 5), 128'h0, {64'h0001_0001_0001_0001, 64'h0},
                128'h0, "R6");
    // R9 unsigned sub size2: 0 - 1 wraps to all ones
    apply_known(mk(2, 0, 1, 1, 6), 128'h0, {64'h0, 64'h0000_0001_0000_0001},
                {128{1'b1}}, "R9");

    // full sweep of sizes, halves, signedness and operation
    for (int sz = 0; sz < 3; sz++)
      for (int q = 0; q < 2; q++)
        for (int u = 0; u < 2; u++)
          for (int sb = 0; sb < 2; sb++)
            for (int p = 0; p < 6; p++)
              apply(mk(sz, q[0], u[0], sb[0], p + sz), {pats[p], pats[(p + 1) % 6]},
                    {pats[(p + 2) % 6], pats[(p + 4) % 6]}, "R5");

    // reserved size
    for (int k = 0; k < 4; k++)
      apply(mk(3, k[0], k[1], 1'b0, 9), {2{pats[k]}}, {2{pats[k + 1]}}, "R4");

    // broken pattern bits
    apply(mk(0, 0, 0, 0, 1) | 32'h8000_0000, '1, '1, "R3");
    apply(mk(1, 0, 1, 1, 1) & ~32'h0020_0000, '1, '1, "R3");
    apply(mk(2, 1, 0, 0, 1) | 32'h0000_4000, '1, '1, "R3");
    apply(mk(0, 0, 1, 0, 1) & ~32'h0000_1000, '1, '1, "R3");
    apply(mk(0, 0, 0, 0, 1) | 32'h1000_0000, '1, '1, "R3");

    // source-index fields do not matter
    for (int k = 0; k < 4; k++) begin
      logic [31:0] w;
      w = mk(1, 1, 0, 1, 17);
      w[20:16] = 5'(k * 7);
      w[9:5]   = 5'(31 - k * 5);
      apply(w, {pats[2], pats[3]}, {pats[5], pats[4]}, "R10");
    end

    // random vectors
    for (int k = 0; k < 300; k++) begin
      logic [31:0] w;
      w = mk($urandom_range(0, 2), 1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 31));
      apply(w, {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, "R9");
    end

    // reset in the middle of a run
    rst = 1'b1;
    insn_i = mk(0, 0, 0, 1, 12); wide_i = '1; narrow_i = '1;
    @(negedge clk);
    compare('0, 1'b0, 5'd0, "R1 mid-run reset");
    rst = 1'b0;
    apply(mk(2, 1, 1, 1, 30), {pats[1], pats[4]}, {pats[4], pats[0]}, "R2");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule